// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block sits between a processor core and a byte-wide external memory bus. The core asks for one access at a time with a start strobe, an 18-bit address, a read/write flag, a code-fetch flag and a write byte. The block returns a one-clock completion strobe and, for reads, the byte that was read. On the bus side, the low address byte and the data byte share one lane. The address goes out first, marked by an address latch strobe, so that an outside latch can hold it. Data follows later in the same cycle. The middle address byte has its own output for the whole cycle. Two optional extra address pins can carry bits 16 and 17, or keep their plain port values.

A strap input is captured once, just after reset is released. While the captured value is 1, code fetches below the on-chip ROM size are served by a one-clock request to the on-chip ROM and do not touch the bus. All other accesses use the external bus. An asynchronous active-low wait input passes through a two-flop synchroniser and can hold the data phase of an external cycle for as long as it stays low.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is asserted, bus_ale=0, bus_rd_n=1, bus_wr_n=1, bus_ad_oe=0, req_done=0 and rom_rd=0.
- R2: Every external cycle begins with exactly one clock in which bus_ale=1, bus_ad_oe=1 and bus_ad_out equals address bits 7:0. This clock is the one after the clock edge that accepts the request.
- R3: bus_hi equals address bits 15:8 in every clock of an external cycle (address latch, hold and data clocks).
- R4: The clock after the address latch clock is a hold clock with bus_ale=0, bus_ad_oe=1, bus_ad_out still equal to address bits 7:0, and both strobes high. The data phase follows it.
- R5: In the data phase of a read, bus_ad_oe=0 and bus_rd_n=0, and req_rdata returns the bus_ad_in value from the last data clock. In the data phase of a write, bus_ad_oe=1, bus_ad_out equals the write byte and bus_wr_n=0.
- R6: With bus_wait_n high, the data phase lasts one clock. If bus_wait_n is low before the cycle starts and is released during data clock k+1 (k>=0, the first data clock counting as 1), the data phase lasts k+3 clocks.
- R7: req_done is high for exactly one clock, in the clock after the last data clock (or after the ROM clock), and req_rdata is valid in that same clock.
- R8: rom_use_strap is captured at the first clock edge after reset is released, and later changes have no effect. If the captured value is 0, every code fetch goes to the external bus.
- R9: If the captured strap is 1, a code fetch with address below ROM_BYTES takes one clock with rom_rd=1 and rom_addr equal to the low address bits, with no bus_ale and no strobe. req_rdata then returns rom_rdata. Code fetches at or above ROM_BYTES, and all data accesses (req_code=0), use the external bus.
- R10: xaddr_cfg selects the extra address pins. With 00, bus_a16 and bus_a17 follow port_a16 and port_a17. With 01, bus_a17 carries address bit 17 and bus_a16 follows port_a16. With 10 or 11, both pins carry address bits 16 and 17.
- R11: A code fetch is always a read, whatever the value of req_write.
- R12: req_valid is accepted only while the block is idle. A strobe during a busy cycle starts no further bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start strobe for one access |
| req_code | input | 1 | 1 = code fetch, 0 = data access |
| req_write | input | 1 | 1 = write (data accesses only) |
| req_addr | input | 18 | Access address |
| req_wdata | input | 8 | Write byte |
| req_done | output | 1 | One-clock completion strobe |
| req_rdata | output | 8 | Read result, valid with req_done |
| rom_rd | output | 1 | On-chip ROM read request |
| rom_addr | output | ROM_AW | On-chip ROM address |
| rom_rdata | input | 8 | On-chip ROM data (combinational) |
| rom_use_strap | input | 1 | Strap captured after reset: 1 allows on-chip code fetches |
| xaddr_cfg | input | 2 | Extra address pin selection |
| port_a16 | input | 1 | Plain port value for bus_a16 |
| port_a17 | input | 1 | Plain port value for bus_a17 |
| bus_wait_n | input | 1 | Asynchronous active-low wait |
| bus_ale | output | 1 | Address latch strobe |
| bus_ad_out | output | 8 | Shared address/data lane, output value |
| bus_ad_oe | output | 1 | Shared lane output enable |
| bus_ad_in | input | 8 | Shared lane, input value |
| bus_hi | output | 8 | Address bits 15:8 |
| bus_a16 | output | 1 | Address bit 16 or port value |
| bus_a17 | output | 1 | Address bit 17 or port value |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |

## Verification
The bench sweeps the length of the wait hold over several values for both reads and writes. A synchroniser with the wrong depth, or a state machine that ignores the synchronised wait, shows up as a data phase of the wrong length. It fetches code at addresses 255 and 256 with a 256-byte ROM. A comparison that is off by one sends one of these fetches to the wrong target, which the bench sees as an address latch pulse where none belongs, or the reverse. It changes the strap after reset, which exposes a design that reads the strap live instead of once. It also sends a code fetch with the write flag set, and a second start strobe in the middle of a cycle. A design that gets these wrong drives a write strobe or starts a phantom second cycle.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    XS_IDLE = 3'd0,
    XS_ROM  = 3'd1,
    XS_ALE  = 3'd2,
    XS_HOLD = 3'd3,
    XS_DATA = 3'd4
  } xb_state_t;

  // decides whether a fetch is served by the on-chip ROM
  function automatic logic xb_onchip(input logic is_code, input logic strap_q,
                                     input logic [31:0] addr, input int unsigned rom_bytes);
    return is_code && strap_q && (addr < rom_bytes);
  endfunction

  // returns {a17_enable, a16_enable} for a selection code
  function automatic logic [1:0] xb_hi_enables(input logic [1:0] cfg);
    logic [1:0] en;
    case (cfg)
      2'b00:   en = 2'b00;
      2'b01:   en = 2'b10;
      default: en = 2'b11;
    endcase
    return en;
  endfunction

  // effective write flag: code fetches are always reads
  function automatic logic xb_eff_write(input logic is_code, input logic wr);
    return wr && !is_code;
  endfunction

endpackage

// File: rtl/xbus_wait_sync.sv
module xbus_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= 1'b1;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/xbus_mode_latch.sv
module xbus_mode_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_in,
  output logic strap_q,
  output logic ready
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q <= 1'b0;
      ready   <= 1'b0;
    end else if (!ready) begin
      strap_q <= strap_in;
      ready   <= 1'b1;
    end
  end
endmodule

// File: rtl/xbus_addr_steer.sv
module xbus_addr_steer #(
  parameter int LANE_W = 8,
  localparam int ADDR_W = 2 * LANE_W + 2
) (
  input  logic [ADDR_W-1:0] addr_q,
  input  logic              bus_active,
  input  logic [1:0]        xaddr_cfg,
  input  logic              port_a16,
  input  logic              port_a17,
  output logic [LANE_W-1:0] bus_hi,
  output logic              bus_a16,
  output logic              bus_a17
);
  import xbus_pkg::*;

  logic [1:0] en;

  always_comb begin
    en      = xb_hi_enables(xaddr_cfg);
    bus_hi  = bus_active ? addr_q[2*LANE_W-1:LANE_W] : '0;
    bus_a17 = en[1] ? addr_q[2*LANE_W+1] : port_a17;
    bus_a16 = en[0] ? addr_q[2*LANE_W]   : port_a16;
  end
endmodule

// File: rtl/xbus_fsm.sv
module xbus_fsm #(
  parameter int LANE_W = 8,
  localparam int ADDR_W = 2 * LANE_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ready,
  input  logic               req_valid,
  input  logic               req_code,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [LANE_W-1:0]  req_wdata,
  input  logic               onchip_hit,
  input  logic               wait_ok,
  input  logic [LANE_W-1:0]  bus_ad_in,
  input  logic [LANE_W-1:0]  rom_rdata,
  output logic [ADDR_W-1:0]  addr_q,
  output logic               bus_ale,
  output logic [LANE_W-1:0]  bus_ad_out,
  output logic               bus_ad_oe,
  output logic               bus_rd_n,
  output logic               bus_wr_n,
  output logic               rom_rd,
  output logic               req_done,
  output logic [LANE_W-1:0]  req_rdata,
  output logic               bus_active
);
  import xbus_pkg::*;

  xb_state_t         state;
  logic              wr_q;
  logic [LANE_W-1:0] wd_q;
  logic              done_q;
  logic [LANE_W-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= XS_IDLE;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wd_q    <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        XS_IDLE: begin
          if (ready && req_valid) begin
            addr_q <= req_addr;
            wr_q   <= xb_eff_write(req_code, req_write);
            wd_q   <= req_wdata;
            state  <= onchip_hit ? XS_ROM : XS_ALE;
          end
        end
        XS_ROM: begin
          rdata_q <= rom_rdata;
          done_q  <= 1'b1;
          state   <= XS_IDLE;
        end
        XS_ALE:  state <= XS_HOLD;
        XS_HOLD: state <= XS_DATA;
        XS_DATA: begin
          if (wait_ok) begin
            if (!wr_q) rdata_q <= bus_ad_in;
            done_q <= 1'b1;
            state  <= XS_IDLE;
          end
        end
        default: state <= XS_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_ale    = 1'b0;
    bus_ad_out = '0;
    bus_ad_oe  = 1'b0;
    bus_rd_n   = 1'b1;
    bus_wr_n   = 1'b1;
    rom_rd     = 1'b0;
    bus_active = 1'b0;
    case (state)
      XS_ROM: rom_rd = 1'b1;
      XS_ALE: begin
        bus_active = 1'b1;
        bus_ale    = 1'b1;
        bus_ad_oe  = 1'b1;
        bus_ad_out = addr_q[LANE_W-1:0];
      end
      XS_HOLD: begin
        bus_active = 1'b1;
        bus_ad_oe  = 1'b1;
        bus_ad_out = addr_q[LANE_W-1:0];
      end
      XS_DATA: begin
        bus_active = 1'b1;
        if (wr_q) begin
          bus_ad_oe  = 1'b1;
          bus_ad_out = wd_q;
          bus_wr_n   = 1'b0;
        end else begin
          bus_rd_n   = 1'b0;
        end
      end
      default: ;
    endcase
  end

  assign req_done  = done_q;
  assign req_rdata = rdata_q;
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl #(
  parameter int LANE_W    = 8,
  parameter int ROM_BYTES = 4096,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = 2 * LANE_W + 2,
  localparam int ROM_AW = $clog2(ROM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_code,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANE_W-1:0] req_wdata,
  output logic              req_done,
  output logic [LANE_W-1:0] req_rdata,
  output logic              rom_rd,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [LANE_W-1:0] rom_rdata,
  input  logic              rom_use_strap,
  input  logic [1:0]        xaddr_cfg,
  input  logic              port_a16,
  input  logic              port_a17,
  input  logic              bus_wait_n,
  output logic              bus_ale,
  output logic [LANE_W-1:0] bus_ad_out,
  output logic              bus_ad_oe,
  input  logic [LANE_W-1:0] bus_ad_in,
  output logic [LANE_W-1:0] bus_hi,
  output logic              bus_a16,
  output logic              bus_a17,
  output logic              bus_rd_n,
  output logic              bus_wr_n
);
  import xbus_pkg::*;

  // internal events brought out for the checker
  logic              wait_ok;
  logic              mode_q;
  logic              mode_ready;
  logic              onchip_hit;
  logic              bus_active;
  logic [ADDR_W-1:0] addr_q;

  xbus_wait_sync #(.STAGES(SYNC_STAGES)) wait_sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (bus_wait_n),
    .sync_out (wait_ok)
  );

  xbus_mode_latch mode_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strap_in (rom_use_strap),
    .strap_q  (mode_q),
    .ready    (mode_ready)
  );

  assign onchip_hit = xb_onchip(req_code, mode_q, 32'(req_addr), ROM_BYTES);

  xbus_fsm #(.LANE_W(LANE_W)) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready      (mode_ready),
    .req_valid  (req_valid),
    .req_code   (req_code),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .onchip_hit (onchip_hit),
    .wait_ok    (wait_ok),
    .bus_ad_in  (bus_ad_in),
    .rom_rdata  (rom_rdata),
    .addr_q     (addr_q),
    .bus_ale    (bus_ale),
    .bus_ad_out (bus_ad_out),
    .bus_ad_oe  (bus_ad_oe),
    .bus_rd_n   (bus_rd_n),
    .bus_wr_n   (bus_wr_n),
    .rom_rd     (rom_rd),
    .req_done   (req_done),
    .req_rdata  (req_rdata),
    .bus_active (bus_active)
  );

  xbus_addr_steer #(.LANE_W(LANE_W)) steer_i (
    .addr_q     (addr_q),
    .bus_active (bus_active),
    .xaddr_cfg  (xaddr_cfg),
    .port_a16   (port_a16),
    .port_a17   (port_a17),
    .bus_hi     (bus_hi),
    .bus_a16    (bus_a16),
    .bus_a17    (bus_a17)
  );

  assign rom_addr = addr_q[ROM_AW-1:0];
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
  parameter int LANE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_ale,
  input logic              bus_rd_n,
  input logic              bus_wr_n,
  input logic              bus_ad_oe,
  input logic [LANE_W-1:0] bus_hi,
  input logic              req_done,
  input logic              rom_rd,
  input logic              wait_ok,
  input logic              bus_active,
  input logic              mode_q,
  input logic              mode_ready
);
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) bus_ale |=> !bus_ale); // R2
  AST_HOLD_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |=> (bus_rd_n && bus_wr_n && bus_ad_oe)); // R4
  AST_HI_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && !bus_ale) |-> $stable(bus_hi)); // R3
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) !bus_rd_n |-> !bus_ad_oe); // R5
  AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) !bus_wr_n |-> bus_ad_oe); // R5
  AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n && !wait_ok) |=> !bus_rd_n); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) req_done |=> !req_done); // R7
  AST_STRAP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ready && !mode_q) |-> !rom_rd); // R8
  AST_ROM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd |-> (!bus_ale && bus_rd_n && bus_wr_n && !bus_ad_oe)); // R9
endmodule

bind xbus_ctrl xbus_ctrl_chk #(.LANE_W(LANE_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_ale    (bus_ale),
  .bus_rd_n   (bus_rd_n),
  .bus_wr_n   (bus_wr_n),
  .bus_ad_oe  (bus_ad_oe),
  .bus_hi     (bus_hi),
  .req_done   (req_done),
  .rom_rd     (rom_rd),
  .wait_ok    (wait_ok),
  .bus_active (bus_active),
  .mode_q     (mode_q),
  .mode_ready (mode_ready)
);

// File: tb/xbus_ctrl_tb_top.sv
module xbus_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int ROMB  = 256;
  localparam int WDOG  = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_code = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_done;
  logic [7:0]  req_rdata;
  logic        rom_rd;
  logic [7:0]  rom_addr;
  logic [7:0]  rom_rdata;
  logic        rom_use_strap = 1'b1;
  logic [1:0]  xaddr_cfg = 2'b00;
  logic        port_a16 = 1'b0, port_a17 = 1'b0;
  logic        bus_wait_n = 1'b1;
  logic        bus_ale, bus_ad_oe, bus_a16, bus_a17, bus_rd_n, bus_wr_n;
  logic [7:0]  bus_ad_out, bus_ad_in = '0, bus_hi;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_P/2) clk = ~clk;

  assign rom_rdata = rom_addr ^ 8'hC3;

  xbus_ctrl #(.LANE_W(8), .ROM_BYTES(ROMB), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_done(req_done), .req_rdata(req_rdata), .rom_rd(rom_rd),
    .rom_addr(rom_addr), .rom_rdata(rom_rdata), .rom_use_strap(rom_use_strap),
    .xaddr_cfg(xaddr_cfg), .port_a16(port_a16), .port_a17(port_a17),
    .bus_wait_n(bus_wait_n), .bus_ale(bus_ale), .bus_ad_out(bus_ad_out),
    .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in), .bus_hi(bus_hi),
    .bus_a16(bus_a16), .bus_a17(bus_a17), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic do_reset(input bit strap);
    rst_n = 1'b0;
    rom_use_strap = strap;
    repeat (2) @(negedge clk);
    check(!bus_ale && bus_rd_n && bus_wr_n && !bus_ad_oe && !req_done && !rom_rd,
          "R1 reset outputs", {bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe, req_done, rom_rd},
          6'b011000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // k < 0: no wait; exp_on: expected on-chip service
  task automatic do_access(input bit code, input bit wr, input logic [17:0] a,
                           input logic [7:0] wd, input logic [1:0] cfg, input int k,
                           input bit exp_on, input bit poke_busy);
    logic [7:0] lane;
    bit eff_wr;
    int n;
    int exp_n;
    bit e17, e16;
    lane   = a[7:0] ^ 8'h5A;
    eff_wr = wr && !code;
    xaddr_cfg = cfg;
    bus_ad_in = lane;
    req_code = code; req_write = wr; req_addr = a; req_wdata = wd;
    if (k >= 0) begin
      bus_wait_n = 1'b0;
      repeat (3) @(negedge clk);
    end
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_on) begin
      check(rom_rd == 1'b1, "R9 rom_rd in on-chip fetch", rom_rd, 1);
      check(bus_ale == 1'b0 && bus_rd_n && bus_wr_n, "R9 no bus activity on-chip",
            {bus_ale, bus_rd_n, bus_wr_n}, 3'b011);
      check(rom_addr == a[7:0], "R9 rom_addr", rom_addr, a[7:0]);
      @(negedge clk);
      check(req_done == 1'b1, "R7 done after rom clock", req_done, 1);
      check(req_rdata == (a[7:0] ^ 8'hC3), "R9 rom read data", req_rdata, a[7:0] ^ 8'hC3);
      check(bus_ale == 1'b0, "R9 no ale after rom", bus_ale, 0);
      @(negedge clk);
      check(req_done == 1'b0, "R7 done single clock", req_done, 0);
    end else begin
      e17 = (cfg != 2'b00) ? a[17] : port_a17;
      e16 = cfg[1] ? a[16] : port_a16;
      check(rom_rd == 1'b0, "R9 external routing", rom_rd, 0);
      check(bus_ale == 1'b1 && bus_ad_oe == 1'b1, "R2 ale clock", {bus_ale, bus_ad_oe}, 2'b11);
      check(bus_ad_out == a[7:0], "R2 low address on lane", bus_ad_out, a[7:0]);
      check(bus_hi == a[15:8], "R3 upper address in ale clock", bus_hi, a[15:8]);
      check(bus_a17 == e17, "R10 a17 pin", bus_a17, e17);
      check(bus_a16 == e16, "R10 a16 pin", bus_a16, e16);
      @(negedge clk);
      check(bus_ale == 1'b0 && bus_ad_oe == 1'b1 && bus_rd_n && bus_wr_n, "R4 hold clock",
            {bus_ale, bus_ad_oe, bus_rd_n, bus_wr_n}, 4'b0111);
      check(bus_ad_out == a[7:0], "R4 address held", bus_ad_out, a[7:0]);
      check(bus_hi == a[15:8], "R3 upper address in hold", bus_hi, a[15:8]);
      if (poke_busy) req_valid = 1'b1;
      n = 0;
      @(negedge clk);
      while ((eff_wr ? !bus_wr_n : !bus_rd_n) && n < 64) begin
        n++;
        if (n == 1) begin
          if (poke_busy) req_valid = 1'b0;
          if (eff_wr) begin
            check(!bus_wr_n && bus_rd_n && bus_ad_oe, "R5 write strobes",
                  {bus_wr_n, bus_rd_n, bus_ad_oe}, 3'b011);
            check(bus_ad_out == wd, "R5 write byte on lane", bus_ad_out, wd);
          end else begin
            check(!bus_rd_n && bus_wr_n && !bus_ad_oe, code ? "R11 fetch is read" : "R5 read strobes",
                  {bus_rd_n, bus_wr_n, bus_ad_oe}, 3'b010);
          end
          check(bus_hi == a[15:8], "R3 upper address in data", bus_hi, a[15:8]);
        end
        if (k >= 0 && n == k + 1) bus_wait_n = 1'b1;
        @(negedge clk);
      end
      exp_n = (k < 0) ? 1 : k + 3;
      check(n == exp_n, "R6 data phase length", n, exp_n);
      check(req_done == 1'b1, "R7 done after data phase", req_done, 1);
      if (!eff_wr) check(req_rdata == lane, "R5 read data", req_rdata, lane);
      @(negedge clk);
      check(req_done == 1'b0, "R7 done single clock", req_done, 0);
      if (poke_busy) begin
        for (int j = 0; j < 3; j++) begin
          check(!bus_ale && bus_rd_n && bus_wr_n, "R12 busy strobe ignored",
                {bus_ale, bus_rd_n, bus_wr_n}, 3'b011);
          @(negedge clk);
        end
      end
    end
    bus_wait_n = 1'b1;
  endtask

  initial begin
    logic [17:0] a;
    @(negedge clk);
    do_reset(1'b1);

    // address / pin-selection sweep over data accesses
    for (int i = 0; i < 16; i++) begin
      a = 18'((i * 32'h2D35 + 32'h1A3 + i * 32'h10000));
      port_a16 = i[2];
      port_a17 = i[3];
      do_access(1'b0, i[0], a, 8'(i * 37 + 5), 2'(i), -1, 1'b0, 1'b0);
    end

    // wait-length sweep, reads and writes
    for (int k = 0; k < 6; k++) begin
      do_access(1'b0, 1'b0, 18'(32'h2A5C3 + k * 32'h111), 8'h00, 2'b11, k, 1'b0, 1'b0);
      do_access(1'b0, 1'b1, 18'(32'h15A3C + k * 32'h222), 8'(8'h90 + k), 2'b01, k, 1'b0, 1'b0);
    end

    // ROM boundary and routing
    do_access(1'b1, 1'b0, 18'd0,       8'h00, 2'b00, -1, 1'b1, 1'b0);
    do_access(1'b1, 1'b0, 18'd255,     8'h00, 2'b00, -1, 1'b1, 1'b0);
    do_access(1'b1, 1'b0, 18'd256,     8'h00, 2'b00, -1, 1'b0, 1'b0);
    do_access(1'b1, 1'b0, 18'h3FFFF,   8'h00, 2'b10, -1, 1'b0, 1'b0);
    do_access(1'b0, 1'b0, 18'd5,       8'h00, 2'b00, -1, 1'b0, 1'b0);
    do_access(1'b1, 1'b1, 18'd300,     8'h77, 2'b00, -1, 1'b0, 1'b0); // R11
    do_access(1'b1, 1'b1, 18'd7,       8'h77, 2'b00, -1, 1'b1, 1'b0); // R11 on-chip
    do_access(1'b1, 1'b0, 18'd310,     8'h00, 2'b00,  1, 1'b0, 1'b0);

    // busy strobe
    do_access(1'b0, 1'b0, 18'h01234,   8'h00, 2'b00, -1, 1'b0, 1'b1); // R12
    do_access(1'b0, 1'b1, 18'h04321,   8'h3C, 2'b00,  2, 1'b0, 1'b1); // R12

    // strap changes after capture have no effect (R8)
    rom_use_strap = 1'b0;
    do_access(1'b1, 1'b0, 18'd9,       8'h00, 2'b00, -1, 1'b1, 1'b0);

    do_reset(1'b0);
    do_access(1'b1, 1'b0, 18'd9,       8'h00, 2'b00, -1, 1'b0, 1'b0); // R8 all off-chip
    rom_use_strap = 1'b1;
    do_access(1'b1, 1'b0, 18'd9,       8'h00, 2'b00, -1, 1'b0, 1'b0); // R8 no live effect
    do_access(1'b1, 1'b0, 18'd200,     8'h00, 2'b01,  2, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule